// File: doc/BRIEF.md
# Store-and-Forward Packet Gate

This block sits between a network receive port and the logic behind it. Packets arrive as streams of beats. Each beat has a 64-bit data word, a 4-bit user sideband and an end-of-packet flag, and moves on a valid/ready handshake. The gate writes every beat into an internal buffer. It shows nothing on its output until the final beat of that packet has been stored. It then sends the complete packet downstream as one continuous burst, so downstream resources are never held while a slow sender finishes a packet.

The top bit of the user sideband carries an error flag, and the gate samples it on the final beat. A packet whose final beat has the flag set is thrown away inside the gate. It is dropped by moving the write pointer back to where the packet started, so the packet never reaches the output. A packet longer than the whole buffer is also dropped, and the input stays ready so the sender is never deadlocked. The synchronous `clr` input empties the buffer just as `rst` does.

The write side is a three-state machine:
- `WR_HEAD`: waiting for the first beat.
- `WR_BODY`: storing a packet. The transitions between `WR_HEAD` and `WR_BODY` are *first beat* and *end of packet* (commit or error drop).
- `WR_SKIP`: swallowing the rest of an oversize packet. It is entered by *overflow drop* and left on *end of packet*.

The read side has two states, `RD_IDLE` and `RD_SEND`:
- *Committed data seen* moves it from `RD_IDLE` to `RD_SEND`.
- *Drained* moves it back, after the last beat of the last committed packet has been handed over.

The two sides share only a commit pointer and the read pointer.

Top module: `sfg_packet_gate`

## Requirements
- R1: No beat of a packet appears on the output before that packet's last beat is accepted. With the output side idle and `out_ready` high, `out_valid` stays low in the cycle after the last beat is accepted and goes high one cycle later.
- R2: A good packet leaves with every beat's data, user field and last flag unchanged, in arrival order, with last set only on its final beat.
- R3: The error flag is bit 3 of `in_user`, sampled only on the beat with `in_last` = 1. When it is 1 the whole packet is discarded. When it is set on any earlier beat it has no effect on dropping, and the bit is passed through as stored.
- R4: Once `out_valid` rises for a packet, it stays high until the beat with `out_last` has been taken. One beat moves per cycle while `out_ready` is high. While `out_ready` is low, `out_valid` and `out_data` hold.
- R5: `in_ready` falls only when the buffer holds 2^DEPTH_LOG2 words and at least one committed packet is waiting to drain. Storing and sending proceed in the same cycles without stalling each other.
- R6: A packet of up to 2^DEPTH_LOG2 beats is accepted and delivered. A longer packet is dropped entirely, `in_ready` stays high for all of its beats, and later packets are delivered normally.
- R7: After `rst`, or one cycle after `clr`, `out_valid` is 0 and `in_ready` is 1. All committed and partially stored packets are gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous flush, active high |
| in_data | input | 64 | Incoming data word |
| in_user | input | 4 | Incoming sideband; bit 3 is the error flag |
| in_last | input | 1 | Final beat of incoming packet |
| in_valid | input | 1 | Incoming beat valid |
| in_ready | output | 1 | Gate can take a beat |
| out_data | output | 64 | Outgoing data word |
| out_user | output | 4 | Outgoing sideband |
| out_last | output | 1 | Final beat of outgoing packet |
| out_valid | output | 1 | Outgoing beat valid |
| out_ready | input | 1 | Downstream takes the beat |

## Verification
The bench keeps the default 64-bit data and 4-bit user widths but builds the gate with DEPTH_LOG2 = 4, a 16-word buffer. At that size, a single test packet can fill the buffer exactly, overflow it by a few beats, or share it with a blocked second packet. This puts the full-stall rule, the exact-capacity boundary and the oversize drop within reach of short directed runs. The error-drop, pass-through and flush paths do not depend on depth and are covered at the same size.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

    // Write-side states: waiting for a first beat, storing a packet,
    // swallowing the tail of a packet that outgrew the buffer.
    typedef enum logic [1:0] {
        WR_HEAD = 2'd0,
        WR_BODY = 2'd1,
        WR_SKIP = 2'd2
    } wr_state_e;

    // Read-side states: nothing committed, or bursting committed beats.
    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_SEND = 1'b1
    } rd_state_e;

endpackage

// File: rtl/sfg_store.sv
module sfg_store #(
    parameter int WORD_W = 69,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_word;
        end
    end

    // Read port is combinational so a committed word is on the output
    // in the same cycle the read pointer reaches it.
    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/sfg_wr_ctrl.sv
module sfg_wr_ctrl
    import sfg_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                in_valid,
    input  logic                in_last,
    input  logic                in_err,
    output logic                in_ready,
    input  logic [ADDR_W:0]     rd_ptr,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [ADDR_W:0]     commit_ptr
);
    localparam int PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1) << ADDR_W;
    localparam logic [PTR_W-1:0] ONE_P   = PTR_W'(1);

    wr_state_e        state, state_nx;
    logic [PTR_W-1:0] wr_ptr, wr_ptr_nx, commit_nx;
    logic [PTR_W-1:0] fill;
    logic             full, oversize, accept;

    // State register.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state <= WR_HEAD;
        end else begin
            state <= state_nx;
        end
    end

    // Pointer registers.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr     <= '0;
            commit_ptr <= '0;
        end else begin
            wr_ptr     <= wr_ptr_nx;
            commit_ptr <= commit_nx;
        end
    end

    // Outputs and next-state decode.
    always_comb begin
        fill      = wr_ptr - rd_ptr;
        full      = (fill == DEPTH_P);
        // Full with nothing committed: the packet alone fills the buffer.
        oversize  = full && (commit_ptr == rd_ptr) && (state != WR_SKIP);
        in_ready  = (state == WR_SKIP) || !full || oversize;
        accept    = in_valid && in_ready;
        wr_en     = 1'b0;
        state_nx  = state;
        wr_ptr_nx = wr_ptr;
        commit_nx = commit_ptr;
        unique case (state)
            WR_HEAD, WR_BODY: begin
                if (accept) begin
                    if (oversize) begin
                        // overflow drop
                        wr_ptr_nx = commit_ptr;
                        state_nx  = in_last ? WR_HEAD : WR_SKIP;
                    end else begin
                        wr_en = 1'b1;
                        if (in_last) begin
                            // end of packet: commit or error drop
                            state_nx = WR_HEAD;
                            if (in_err) begin
                                wr_ptr_nx = commit_ptr;
                            end else begin
                                wr_ptr_nx = wr_ptr + ONE_P;
                                commit_nx = wr_ptr + ONE_P;
                            end
                        end else begin
                            // first beat or continuing body
                            wr_ptr_nx = wr_ptr + ONE_P;
                            state_nx  = WR_BODY;
                        end
                    end
                end
            end
            WR_SKIP: begin
                if (accept && in_last) begin
                    state_nx = WR_HEAD;
                end
            end
            default: state_nx = WR_HEAD;
        endcase
    end

    assign wr_addr = wr_ptr[ADDR_W-1:0];

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst || clr)
        fill <= DEPTH_P);

    // R3
    err_drop_chk: assert property (@(posedge clk) disable iff (rst || clr)
        (accept && in_last && in_err) |=> $stable(commit_ptr));

    // R1
    commit_on_last_chk: assert property (@(posedge clk) disable iff (rst || clr)
        !(accept && in_last) |=> $stable(commit_ptr));

    // R6
    skip_rewind_chk: assert property (@(posedge clk) disable iff (rst || clr)
        (accept && oversize) |=> (wr_ptr == commit_ptr));

endmodule

// File: rtl/sfg_rd_ctrl.sv
module sfg_rd_ctrl
    import sfg_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic [ADDR_W:0] commit_ptr,
    input  logic            rd_last,
    input  logic            out_ready,
    output logic            out_valid,
    output logic [ADDR_W:0] rd_ptr
);
    localparam int PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] ONE_P = PTR_W'(1);

    rd_state_e        state, state_nx;
    logic [PTR_W-1:0] rd_ptr_nx;
    logic             avail;

    // State register.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state  <= RD_IDLE;
            rd_ptr <= '0;
        end else begin
            state  <= state_nx;
            rd_ptr <= rd_ptr_nx;
        end
    end

    // Outputs and next-state decode.
    always_comb begin
        avail     = (commit_ptr != rd_ptr);
        out_valid = (state == RD_SEND);
        state_nx  = state;
        rd_ptr_nx = rd_ptr;
        unique case (state)
            RD_IDLE: begin
                // committed data seen
                if (avail) begin
                    state_nx = RD_SEND;
                end
            end
            RD_SEND: begin
                if (out_ready) begin
                    rd_ptr_nx = rd_ptr + ONE_P;
                    // drained
                    if (rd_last && (commit_ptr == rd_ptr + ONE_P)) begin
                        state_nx = RD_IDLE;
                    end
                end
            end
            default: state_nx = RD_IDLE;
        endcase
    end

    // R1
    send_has_data_chk: assert property (@(posedge clk) disable iff (rst || clr)
        out_valid |-> (commit_ptr != rd_ptr));

    // R4
    burst_gap_chk: assert property (@(posedge clk) disable iff (rst || clr)
        (out_valid && out_ready && !rd_last) |=> out_valid);

    // R4
    hold_ptr_chk: assert property (@(posedge clk) disable iff (rst || clr)
        (out_valid && !out_ready) |=> (out_valid && $stable(rd_ptr)));

endmodule

// File: rtl/sfg_packet_gate.sv
module sfg_packet_gate #(
    parameter int DATA_W     = 64,
    parameter int USER_W     = 4,
    parameter int DEPTH_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [USER_W-1:0] in_user,
    input  logic              in_last,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [USER_W-1:0] out_user,
    output logic              out_last,
    output logic              out_valid,
    input  logic              out_ready
);
    localparam int WORD_W = 1 + USER_W + DATA_W;
    localparam int PTR_W  = DEPTH_LOG2 + 1;
    localparam int ERR_B  = USER_W - 1;

    logic                  wr_en;
    logic [DEPTH_LOG2-1:0] wr_addr;
    logic [PTR_W-1:0]      commit_ptr, rd_ptr;
    logic [WORD_W-1:0]     wr_word, rd_word;

    assign wr_word = {in_last, in_user, in_data};

    sfg_wr_ctrl #(.ADDR_W(DEPTH_LOG2)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_err     (in_user[ERR_B]),
        .in_ready   (in_ready),
        .rd_ptr     (rd_ptr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .commit_ptr (commit_ptr)
    );

    sfg_store #(.WORD_W(WORD_W), .ADDR_W(DEPTH_LOG2)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_word (wr_word),
        .rd_addr (rd_ptr[DEPTH_LOG2-1:0]),
        .rd_word (rd_word)
    );

    sfg_rd_ctrl #(.ADDR_W(DEPTH_LOG2)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .commit_ptr (commit_ptr),
        .rd_last    (out_last),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .rd_ptr     (rd_ptr)
    );

    assign {out_last, out_user, out_data} = rd_word;

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !out_valid);

    // R4
    hold_data_chk: assert property (@(posedge clk) disable iff (rst || clr)
        (out_valid && !out_ready) |=> $stable(out_data));

endmodule

// File: tb/sfg_packet_gate_tb.sv
module sfg_packet_gate_tb;
    localparam int DATA_W = 64;
    localparam int USER_W = 4;
    localparam int DLOG   = 4;
    localparam int NVEC   = 8;

    // Vector table: packet length, error on last beat, error bit on beat 0.
    localparam int VLEN  [NVEC] = '{1, 3, 5, 16, 2, 6, 1, 4};
    localparam bit VERRL [NVEC] = '{0, 0, 1, 0, 1, 0, 1, 0};
    localparam bit VERRM [NVEC] = '{0, 0, 0, 0, 0, 1, 0, 0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic [USER_W-1:0] in_user = '0;
    logic in_last = 1'b0, in_valid = 1'b0, in_ready;
    logic [DATA_W-1:0] out_data;
    logic [USER_W-1:0] out_user;
    logic out_last, out_valid;
    logic out_ready = 1'b1;

    always #5 clk = ~clk;

    sfg_packet_gate #(.DATA_W(DATA_W), .USER_W(USER_W), .DEPTH_LOG2(DLOG)) u_dut (
        .clk(clk), .rst(rst), .clr(clr),
        .in_data(in_data), .in_user(in_user), .in_last(in_last),
        .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_user(out_user), .out_last(out_last),
        .out_valid(out_valid), .out_ready(out_ready)
    );

    int n_chk = 0, n_err = 0;
    int rx_cnt = 0, rd_idx = 0, acc_cnt = 0, stall_cnt = 0, gap_cnt = 0;
    bit mid = 0, done = 0;
    logic [DATA_W-1:0] rx_data [256];
    logic [USER_W-1:0] rx_user [256];
    logic              rx_last [256];

    function automatic logic [DATA_W-1:0] wd(int pid, int b);
        logic [15:0] p = 16'(pid);
        logic [15:0] q = 16'(b);
        return {p, q, 32'hA5C3_0000 ^ {p, q}};
    endfunction

    function automatic logic [USER_W-1:0] wu(int pid, int b, bit e);
        return {e, 3'(pid + b)};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Output and input monitors, sampled mid-cycle.
    always @(negedge clk) begin
        if (!rst && !clr) begin
            if (mid && !out_valid) gap_cnt++;
            if (out_valid && out_ready && rx_cnt < 256) begin
                rx_data[rx_cnt] = out_data;
                rx_user[rx_cnt] = out_user;
                rx_last[rx_cnt] = out_last;
                rx_cnt++;
                mid = !out_last;
            end
            if (in_valid && in_ready) acc_cnt++;
        end
    end

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic drive_beat(int pid, int b, bit last, bit e);
        in_valid = 1'b1;
        in_data  = wd(pid, b);
        in_user  = wu(pid, b, e);
        in_last  = last;
        @(negedge clk);
        while (!in_ready) begin
            stall_cnt++;
            @(negedge clk);
        end
    endtask

    task automatic send_pkt(int pid, int len, bit errl, bit errm, bit hold_chk);
        int rx0 = rx_cnt;
        for (int b = 0; b < len; b++) begin
            bit last = (b == len - 1);
            drive_beat(pid, b, last, last ? errl : (errm && b == 0));
            if (last && hold_chk) begin
                chk(!out_valid && rx_cnt == rx0, "R1", "output before last beat",
                    64'(out_valid), 64'd0);
            end
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (hold_chk) begin
            @(negedge clk);
            chk(!out_valid, "R1", "valid one cycle after last", 64'(out_valid), 64'd0);
            @(negedge clk);
            chk(out_valid == !errl, "R1", "valid two cycles after last",
                64'(out_valid), 64'(!errl));
            @(posedge clk); #1;
        end
    endtask

    task automatic check_pkt(int pid, int len, bit errm, string req);
        if (rx_cnt < rd_idx + len) begin
            chk(0, req, "beats received", 64'(rx_cnt - rd_idx), 64'(len));
        end else begin
            for (int b = 0; b < len; b++) begin
                logic [USER_W-1:0] eu = wu(pid, b, errm && b == 0 && len > 1);
                chk(rx_data[rd_idx+b] == wd(pid, b), req, "data", rx_data[rd_idx+b], wd(pid, b));
                chk(rx_user[rd_idx+b] == eu, req, "user", 64'(rx_user[rd_idx+b]), 64'(eu));
                chk(rx_last[rd_idx+b] == (b == len - 1), req, "last",
                    64'(rx_last[rd_idx+b]), 64'(b == len - 1));
            end
        end
        rd_idx += len;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung run expected completion");
        finish_run();
    end

    initial begin
        int acc0, st0, rx0;
        wait_cycles(3);
        rst = 1'b0;
        #1;
        @(negedge clk);
        // R7 reset state
        chk(!out_valid, "R7", "out_valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready, "R7", "in_ready after reset", 64'(in_ready), 64'd1);
        @(posedge clk); #1;

        // Table walk: R1, R2, R3, R6 (exact capacity at 16 beats)
        for (int i = 0; i < NVEC; i++) begin
            send_pkt(i + 1, VLEN[i], VERRL[i], VERRM[i], 1);
            wait_cycles(VLEN[i] + 4);
            if (!VERRL[i]) check_pkt(i + 1, VLEN[i], VERRM[i], VLEN[i] == 16 ? "R6" : "R2");
            chk(rx_cnt == rd_idx, VERRL[i] ? "R3" : "R2", "total beats out",
                64'(rx_cnt), 64'(rd_idx));
        end
        // R4 no bubbles inside bursts
        chk(gap_cnt == 0, "R4", "mid-packet gaps", 64'(gap_cnt), 64'd0);

        // R5 full with committed packet blocks input; R4 hold while stalled
        out_ready = 1'b0;
        acc0 = acc_cnt;
        send_pkt(20, 10, 0, 0, 0);
        fork
            send_pkt(21, 10, 0, 0, 0);
            begin
                for (int k = 0; k < 40; k++) begin
                    @(negedge clk);
                    if (in_valid && !in_ready) break;
                end
                chk(acc_cnt - acc0 == 16, "R5", "beats accepted before stall",
                    64'(acc_cnt - acc0), 64'd16);
                chk(out_valid && out_data == wd(20, 0), "R4", "held first beat",
                    out_data, wd(20, 0));
                @(negedge clk);
                chk(out_valid && out_data == wd(20, 0), "R4", "still held",
                    out_data, wd(20, 0));
                @(posedge clk); #1;
                out_ready = 1'b1;
            end
        join
        wait_cycles(30);
        check_pkt(20, 10, 0, "R5");
        check_pkt(21, 10, 0, "R5");
        chk(gap_cnt == 0, "R4", "gaps under backpressure", 64'(gap_cnt), 64'd0);

        // R6 oversize packet dropped without stalling, then recovery
        st0 = stall_cnt;
        rx0 = rx_cnt;
        send_pkt(30, 20, 0, 0, 0);
        wait_cycles(25);
        chk(stall_cnt == st0, "R6", "stalls during oversize", 64'(stall_cnt - st0), 64'd0);
        chk(rx_cnt == rx0, "R6", "oversize beats out", 64'(rx_cnt - rx0), 64'd0);
        send_pkt(31, 3, 0, 0, 1);
        wait_cycles(8);
        check_pkt(31, 3, 0, "R6");

        // R7 clear flushes committed and partial packets
        out_ready = 1'b0;
        send_pkt(40, 4, 0, 0, 0);
        drive_beat(41, 0, 0, 0);
        @(posedge clk); #1;
        drive_beat(41, 1, 0, 0);
        @(posedge clk); #1;
        in_valid = 1'b0;
        clr = 1'b1;
        @(posedge clk); #1;
        clr = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R7", "out_valid after clear", 64'(out_valid), 64'd0);
        chk(in_ready, "R7", "in_ready after clear", 64'(in_ready), 64'd1);
        @(posedge clk); #1;
        out_ready = 1'b1;
        rx0 = rx_cnt;
        wait_cycles(10);
        chk(rx_cnt == rx0, "R7", "beats out after clear", 64'(rx_cnt - rx0), 64'd0);
        send_pkt(42, 2, 0, 0, 1);
        wait_cycles(6);
        check_pkt(42, 2, 0, "R7");
        chk(rx_cnt == rd_idx, "R7", "total beats after clear", 64'(rx_cnt), 64'(rd_idx));

        finish_run();
    end

endmodule